// File: doc/BRIEF.md
# Nested Trap Entry Controller

This block performs the entry half of exception handling for a 64-bit processor with register windows and several nested trap levels. When a trap request is sampled, it saves the interrupted context into a small per-level trap stack. It then computes the privileged state word, the adjusted window pointer, the raised trap level and the vector to fetch from. All of this happens in one clock. The new values come out on registered outputs, together with a one-cycle completion strobe.

The core drives the current architectural state on the inputs and commits the outputs when the strobe fires. The trap stack has a combinational read port indexed by level, so the return path can fetch a saved record. A request made while the trap level is already at its ceiling is treated as unrecoverable. The block raises an error flag that stays set until reset, and takes no further traps.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the completion strobe and the error flag are 0, and every trap stack entry reads back as all zeros.
- R2: A taken trap writes the stack entry indexed by the incoming trap level. The entry holds:
  - the PC, the next PC and the 9-bit trap type;
  - a 40-bit state word with the condition codes in bits 39:32, the ASI in bits 31:24, the state word ANDed with 0xF3F in bits 19:8, the window pointer in the low bits, and zeros elsewhere.
- R3: The new state word is the incoming one with bit 0 (alternate globals), bit 2 (privileged) and bit 4 (FPU enable) set. The other bits are unchanged except as R8 states.
- R4: Trap type 0x024 (clean window) gives a window pointer one below the current one, modulo the window count.
- R5: A trap type whose bits 8:6 equal 3'b010 (spill group) gives a window pointer equal to (pointer − save count − 2), modulo the window count.
- R6: A trap type whose bits 8:6 equal 3'b011 (fill group) gives a window pointer one above the current one, modulo the window count. Any other trap type leaves the pointer unchanged.
- R7: The new PC is the trap base with bits 14:0 replaced. Bit 14 is 1 when the incoming level exceeds 1, bits 13:5 hold the trap type, and bits 4:0 are zero. The new next PC is the new PC plus 4.
- R8: Below level MAXTL−1 the level rises by one and bit 5 (red state) passes through. At level MAXTL−1, bit 5 is forced to 1 and the level becomes MAXTL.
- R9: A request at level MAXTL or above sets the error flag and gives no strobe. It writes no stack entry. The error flag holds until reset, and all later requests are ignored.
- R10: The strobe rises in the cycle after the request is sampled and lasts one cycle. A request present during the strobe cycle is ignored: outputs and stack keep the first trap's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Trap request |
| tt_i | input | 9 | Trap type |
| pc_i | input | 64 | PC at the trap |
| npc_i | input | 64 | Next PC at the trap |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current address space identifier |
| pstate_i | input | 12 | Current processor state word |
| cwp_i | input | log2(NWIN) | Current window pointer |
| cansave_i | input | log2(NWIN) | Count of windows free for saving |
| tl_i | input | log2(MAXTL+1) | Current trap level |
| tba_i | input | 64 | Trap base register |
| rd_lvl_i | input | log2(MAXTL+1) | Trap stack read index |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Sticky error-state flag |
| pc_o | output | 64 | New PC (trap vector) |
| npc_o | output | 64 | New next PC |
| pstate_o | output | 12 | New processor state word |
| cwp_o | output | log2(NWIN) | New window pointer |
| tl_o | output | log2(MAXTL+1) | New trap level |
| rd_tstate_o | output | 40 | Saved state word at rd_lvl_i |
| rd_tpc_o | output | 64 | Saved PC at rd_lvl_i |
| rd_tnpc_o | output | 64 | Saved next PC at rd_lvl_i |
| rd_tt_o | output | 9 | Saved trap type at rd_lvl_i |

## Verification
The hardest case to reach is a request that collides with the completion strobe. To make the loss visible, the inputs must change during that cycle. The bench holds the request high for two cycles and switches the trap type and the PC in the second cycle. It then checks that the vector outputs and the stack entry still carry the first trap's values. A spill whose pointer arithmetic wraps below zero, and the step from MAXTL−1 into the fatal level, are reached by driving those level and count values directly.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int PC_W     = 64;
    localparam int TT_W     = 9;
    localparam int PST_W    = 12;
    localparam int TSTATE_W = 40;

    localparam logic [PST_W-1:0] PST_SAVE_MASK = 12'hF3F;
    localparam int PST_AG   = 0;
    localparam int PST_PRIV = 2;
    localparam int PST_PEF  = 4;
    localparam int PST_RED  = 5;

    localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
    localparam logic [2:0]      GRP_SPILL    = 3'b010;
    localparam logic [2:0]      GRP_FILL     = 3'b011;

    typedef enum logic [1:0] {
        WADJ_KEEP,
        WADJ_DEC,
        WADJ_SPILL,
        WADJ_INC
    } wadj_e;

    typedef struct packed {
        logic [TSTATE_W-1:0] tstate;
        logic [PC_W-1:0]     tpc;
        logic [PC_W-1:0]     tnpc;
        logic [TT_W-1:0]     tt;
    } trap_rec_t;

    function automatic wadj_e classify_tt(logic [TT_W-1:0] tt);
        if (tt == TT_CLEAN_WIN)         return WADJ_DEC;
        else if (tt[8:6] == GRP_SPILL)  return WADJ_SPILL;
        else if (tt[8:6] == GRP_FILL)   return WADJ_INC;
        else                            return WADJ_KEEP;
    endfunction
endpackage

// File: rtl/trap_win_adj.sv
module trap_win_adj
    import trap_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [TT_W-1:0] tt_i,
    input  logic [CWPW-1:0] cwp_i,
    input  logic [CWPW-1:0] cansave_i,
    output logic [CWPW-1:0] cwp_o
);
    localparam bit POW2 = (NWIN == (1 << CWPW));

    wadj_e action;
    int unsigned raw;

    always_comb begin
        action = classify_tt(tt_i);
        unique case (action)
            WADJ_DEC:   raw = int'(cwp_i) + NWIN - 1;
            WADJ_SPILL: raw = int'(cwp_i) + 2 * NWIN - int'(cansave_i) - 2;
            WADJ_INC:   raw = int'(cwp_i) + 1;
            default:    raw = int'(cwp_i);
        endcase
    end

    generate
        if (POW2) begin : g_trunc
            assign cwp_o = raw[CWPW-1:0];
        end else begin : g_mod
            int unsigned wrapped;
            assign wrapped = raw % NWIN;
            assign cwp_o   = wrapped[CWPW-1:0];
        end
    endgenerate
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
    import trap_pkg::*;
#(
    parameter int TLW = 3
) (
    input  logic [PC_W-1:0] tba_i,
    input  logic [TT_W-1:0] tt_i,
    input  logic [TLW-1:0]  tl_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] npc_o
);
    logic nested;

    always_comb begin
        nested = (tl_i > TLW'(1));
        pc_o   = {tba_i[PC_W-1:15], nested, tt_i, 5'b0};
        npc_o  = pc_o + PC_W'(4);
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int AW    = 3
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  trap_rec_t wr_rec_i,
    input  logic [AW-1:0] rd_idx_i,
    output trap_rec_t rd_rec_o
);
    trap_rec_t stk_d [DEPTH];
    trap_rec_t stk_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            stk_d[i] = stk_q[i];
            if (wr_en_i && (wr_idx_i == AW'(i))) stk_d[i] = wr_rec_i;
        end
        rd_rec_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == AW'(i)) rd_rec_o = stk_q[i];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_ni) stk_q[i] <= '0;
            else         stk_q[i] <= stk_d[i];
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int MAXTL = 5,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int TLW  = $clog2(MAXTL + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    input  logic [8:0]      tt_i,
    input  logic [63:0]     pc_i,
    input  logic [63:0]     npc_i,
    input  logic [7:0]      ccr_i,
    input  logic [7:0]      asi_i,
    input  logic [11:0]     pstate_i,
    input  logic [CWPW-1:0] cwp_i,
    input  logic [CWPW-1:0] cansave_i,
    input  logic [TLW-1:0]  tl_i,
    input  logic [63:0]     tba_i,
    input  logic [TLW-1:0]  rd_lvl_i,
    output logic            done_o,
    output logic            err_o,
    output logic [63:0]     pc_o,
    output logic [63:0]     npc_o,
    output logic [11:0]     pstate_o,
    output logic [CWPW-1:0] cwp_o,
    output logic [TLW-1:0]  tl_o,
    output logic [39:0]     rd_tstate_o,
    output logic [63:0]     rd_tpc_o,
    output logic [63:0]     rd_tnpc_o,
    output logic [8:0]      rd_tt_o
);
    typedef struct packed {
        logic              done;
        logic              err;
        logic [PC_W-1:0]   pc;
        logic [PC_W-1:0]   npc;
        logic [PST_W-1:0]  pstate;
        logic [CWPW-1:0]   cwp;
        logic [TLW-1:0]    tl;
    } regs_t;

    regs_t st_d, st_q;

    logic            take, fatal, wr_en;
    logic [CWPW-1:0] cwp_new;
    logic [PC_W-1:0] vec_pc, vec_npc;
    trap_rec_t       wr_rec, rd_rec;

    trap_win_adj #(.NWIN(NWIN)) win_i (
        .tt_i      (tt_i),
        .cwp_i     (cwp_i),
        .cansave_i (cansave_i),
        .cwp_o     (cwp_new)
    );

    trap_vec_gen #(.TLW(TLW)) vec_i (
        .tba_i (tba_i),
        .tt_i  (tt_i),
        .tl_i  (tl_i),
        .pc_o  (vec_pc),
        .npc_o (vec_npc)
    );

    trap_stack #(.DEPTH(MAXTL), .AW(TLW)) stk_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en),
        .wr_idx_i (tl_i),
        .wr_rec_i (wr_rec),
        .rd_idx_i (rd_lvl_i),
        .rd_rec_o (rd_rec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        take      = req_i && !st_q.done && !st_q.err;
        fatal     = take && (tl_i >= TLW'(MAXTL));
        wr_en     = take && !fatal;

        wr_rec              = '0;
        wr_rec.tstate[39:32] = ccr_i;
        wr_rec.tstate[31:24] = asi_i;
        wr_rec.tstate[19:8]  = pstate_i & PST_SAVE_MASK;
        wr_rec.tstate[CWPW-1:0] = cwp_i;
        wr_rec.tpc  = pc_i;
        wr_rec.tnpc = npc_i;
        wr_rec.tt   = tt_i;

        if (fatal) begin
            st_d.err = 1'b1;
        end else if (take) begin
            st_d.done   = 1'b1;
            st_d.pc     = vec_pc;
            st_d.npc    = vec_npc;
            st_d.cwp    = cwp_new;
            st_d.pstate = pstate_i;
            st_d.pstate[PST_AG]   = 1'b1;
            st_d.pstate[PST_PRIV] = 1'b1;
            st_d.pstate[PST_PEF]  = 1'b1;
            if (tl_i >= TLW'(MAXTL - 1)) st_d.pstate[PST_RED] = 1'b1;
            st_d.tl = tl_i + TLW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign err_o       = st_q.err;
    assign pc_o        = st_q.pc;
    assign npc_o       = st_q.npc;
    assign pstate_o    = st_q.pstate;
    assign cwp_o       = st_q.cwp;
    assign tl_o        = st_q.tl;
    assign rd_tstate_o = rd_rec.tstate;
    assign rd_tpc_o    = rd_rec.tpc;
    assign rd_tnpc_o   = rd_rec.tnpc;
    assign rd_tt_o     = rd_rec.tt;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int MAXTL = 5,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int TLW  = $clog2(MAXTL + 1)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            req_i,
    input logic [8:0]      tt_i,
    input logic [TLW-1:0]  tl_i,
    input logic            done_o,
    input logic            err_o,
    input logic [63:0]     pc_o,
    input logic [11:0]     pstate_o,
    input logic [TLW-1:0]  tl_o
);
    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_fatal_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !done_o && !err_o && (tl_i >= TLW'(MAXTL))) |=> (err_o && !done_o));

    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> (err_o && !done_o));

    p_pstate_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (pstate_o[PST_AG] && pstate_o[PST_PRIV] && pstate_o[PST_PEF]));

    p_vec_tt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((pc_o[13:5] == $past(tt_i)) && (pc_o[4:0] == 5'd0)));

    p_tl_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (tl_o == $past(tl_i) + TLW'(1)));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.NWIN(NWIN), .MAXTL(MAXTL)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .tt_i     (tt_i),
    .tl_i     (tl_i),
    .done_o   (done_o),
    .err_o    (err_o),
    .pc_o     (pc_o),
    .pstate_o (pstate_o),
    .tl_o     (tl_o)
);

// File: tb/trap_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb_top;
    localparam int NWIN = 8;
    localparam int MAXTL = 5;

    logic        clk = 0, rst_n = 0, req = 0;
    logic [8:0]  tt = '0;
    logic [63:0] pc = '0, npc = '0, tba = 64'h0000_1234_5678_0000;
    logic [7:0]  ccr = '0, asi = '0;
    logic [11:0] pst = '0;
    logic [2:0]  cwp = '0, cansave = '0, tl = '0, rd_lvl = '0;
    logic        done, err;
    logic [63:0] o_pc, o_npc, r_tpc, r_tnpc;
    logic [11:0] o_pst;
    logic [2:0]  o_cwp, o_tl;
    logic [39:0] r_tstate;
    logic [8:0]  r_tt;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    trap_entry_ctrl #(.NWIN(NWIN), .MAXTL(MAXTL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .tt_i(tt), .pc_i(pc), .npc_i(npc),
        .ccr_i(ccr), .asi_i(asi), .pstate_i(pst), .cwp_i(cwp), .cansave_i(cansave),
        .tl_i(tl), .tba_i(tba), .rd_lvl_i(rd_lvl), .done_o(done), .err_o(err),
        .pc_o(o_pc), .npc_o(o_npc), .pstate_o(o_pst), .cwp_o(o_cwp), .tl_o(o_tl),
        .rd_tstate_o(r_tstate), .rd_tpc_o(r_tpc), .rd_tnpc_o(r_tnpc), .rd_tt_o(r_tt)
    );

    typedef struct {
        logic [63:0] pc;
        logic [63:0] npc;
        logic [11:0] pst;
        logic [2:0]  cwp;
        logic [2:0]  tl;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req_s, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req_s, act, expv);
        end
    endtask

    function automatic logic [2:0] model_cwp(logic [8:0] t, logic [2:0] c, logic [2:0] s);
        int v;
        if (t == 9'h024)            v = int'(c) - 1;
        else if (t[8:6] == 3'b010)  v = int'(c) - int'(s) - 2;
        else if (t[8:6] == 3'b011)  v = int'(c) + 1;
        else                        v = int'(c);
        v = ((v % NWIN) + NWIN) % NWIN;
        return 3'(v);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R10 unexpected strobe", 64'(done), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(o_pc == e.pc, {"R7 pc ", e.tag}, o_pc, e.pc);
                chk(o_npc == e.npc, {"R7 npc ", e.tag}, o_npc, e.npc);
                chk(o_pst == e.pst, {"R3/R8 pstate ", e.tag}, 64'(o_pst), 64'(e.pst));
                chk(o_cwp == e.cwp, {"R4/R5/R6 cwp ", e.tag}, 64'(o_cwp), 64'(e.cwp));
                chk(o_tl == e.tl, {"R8 tl ", e.tag}, 64'(o_tl), 64'(e.tl));
            end
        end
    end

    task automatic drive(input logic [8:0] t, input logic [2:0] c, input logic [2:0] s,
                         input logic [2:0] l, input logic [11:0] p);
        tt = t; cwp = c; cansave = s; tl = l; pst = p;
        pc = 64'h4000_0000 + {55'd0, t}; npc = pc + 4;
        ccr = {5'd0, c} ^ 8'hA5; asi = {5'd0, l} ^ 8'h80;
    endtask

    task automatic issue(input logic [8:0] t, input logic [2:0] c, input logic [2:0] s,
                         input logic [2:0] l, input logic [11:0] p, input string tag);
        exp_t e;
        @(negedge clk);
        drive(t, c, s, l, p);
        req = 1;
        e.pc  = {tba[63:15], (l > 3'd1), t, 5'b0};
        e.npc = e.pc + 64'd4;
        e.pst = p | 12'h015 | ((l >= 3'(MAXTL - 1)) ? 12'h020 : 12'h000);
        e.cwp = model_cwp(t, c, s);
        e.tl  = l + 3'd1;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 0;
    endtask

    task automatic check_stack(input logic [2:0] lvl, input logic [8:0] t, input logic [2:0] c,
                               input logic [11:0] p, input string req_s);
        logic [39:0] exp_ts;
        logic [63:0] exp_pc;
        exp_pc = 64'h4000_0000 + {55'd0, t};
        exp_ts = {({5'd0, c} ^ 8'hA5), ({5'd0, lvl} ^ 8'h80), 4'h0, (p & 12'hF3F), 5'd0, c};
        rd_lvl = lvl;
        #1;
        chk(r_tstate == exp_ts, {req_s, " tstate"}, 64'(r_tstate), 64'(exp_ts));
        chk(r_tpc == exp_pc, {req_s, " tpc"}, r_tpc, exp_pc);
        chk(r_tnpc == exp_pc + 4, {req_s, " tnpc"}, r_tnpc, exp_pc + 4);
        chk(r_tt == t, {req_s, " tt"}, 64'(r_tt), 64'(t));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] hold_pc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(done == 0, "R1 strobe", 64'(done), 0);
        chk(err == 0, "R1 err", 64'(err), 0);
        for (int i = 0; i < MAXTL; i++) begin
            rd_lvl = 3'(i); #1;
            chk(r_tstate == 0 && r_tpc == 0 && r_tt == 0, "R1 stack zero", r_tpc, 0);
        end

        // generic trap, no window change (R2, R3, R6, R7)
        issue(9'h041, 3'd3, 3'd1, 3'd0, 12'hFFF & ~12'h015, "plain");
        check_stack(3'd0, 9'h041, 3'd3, 12'hFFF & ~12'h015, "R2 level0");
        // R4 clean window wrap 0 -> 7
        issue(9'h024, 3'd0, 3'd2, 3'd1, 12'h0C2, "R4 clean");
        check_stack(3'd1, 9'h024, 3'd0, 12'h0C2, "R2 level1");
        // R5 spill with negative wrap: 2-3-2 -> 5
        issue(9'h088, 3'd2, 3'd3, 3'd2, 12'h100, "R5 spill");
        // R6 fill wrap 7 -> 0
        issue(9'h0C4, 3'd7, 3'd0, 3'd3, 12'h000, "R6 fill");
        // R8 level MAXTL-1 forces red
        issue(9'h060, 3'd4, 3'd1, 3'd4, 12'h000, "R8 red");
        check_stack(3'd4, 9'h060, 3'd4, 12'h000, "R2 level4");

        // R10 request held across the strobe cycle, inputs changed
        @(negedge clk);
        begin
            exp_t e;
            drive(9'h051, 3'd1, 3'd1, 3'd2, 12'h000);
            req = 1;
            e.pc = {tba[63:15], 1'b1, 9'h051, 5'b0}; e.npc = e.pc + 4;
            e.pst = 12'h015; e.cwp = 3'd1; e.tl = 3'd3; e.tag = "R10 first";
            sb.push_back(e);
            hold_pc = e.pc;
        end
        @(negedge clk);
        drive(9'h0AA, 3'd6, 3'd1, 3'd2, 12'h000);
        @(negedge clk);
        req = 0;
        chk(done == 0, "R10 no second strobe", 64'(done), 0);
        chk(o_pc == hold_pc, "R10 pc kept", o_pc, hold_pc);
        check_stack(3'd2, 9'h051, 3'd1, 12'h000, "R10 stack kept");

        // R9 fatal at MAXTL
        @(negedge clk);
        drive(9'h033, 3'd5, 3'd0, 3'(MAXTL), 12'h000);
        req = 1;
        @(negedge clk);
        req = 0;
        chk(err == 1, "R9 err set", 64'(err), 1);
        chk(done == 0, "R9 no strobe", 64'(done), 0);
        check_stack(3'd4, 9'h060, 3'd4, 12'h000, "R9 stack untouched");
        // later legal request ignored
        @(negedge clk);
        drive(9'h045, 3'd2, 3'd0, 3'd1, 12'h000);
        req = 1;
        @(negedge clk);
        req = 0;
        @(negedge clk);
        chk(err == 1, "R9 err sticky", 64'(err), 1);
        chk(o_pc == hold_pc, "R9 outputs frozen", o_pc, hold_pc);
        check_stack(3'd1, 9'h024, 3'd0, 12'h0C2, "R9 later req ignored");

        // reset clears the error (R1)
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(err == 0, "R1 err cleared", 64'(err), 0);
        chk(sb.size() == 0, "R10 scoreboard drained", 64'(sb.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule